// File: doc/BRIEF.md
# Fractional-Ratio Clock Enable Divider

This block derives a slow clock-enable pulse from one of three reference tick streams (a crystal tick and two PLL ticks), each delivered as a one-cycle strobe in the core clock domain. The selected ticks pass through a predivide stage that divides by 2, 2.5 or 3, then through a 7-bit integer stage. A single-cycle `out_tick` pulse marks the end of every output period, so the pulse rate is the source tick rate divided by predivide ratio times integer divisor.

Software programs one 16-bit configuration word through a plain write strobe and a combinational read-back. A configuration change never cuts an output period short. The active settings are replaced only when the current period ends. Clearing the enable bit stops the output at once. A request to run with an illegal setting leaves the output idle and raises a sticky error flag.

The 2.5 ratio uses only the rising edges of the reference. The predivide stage alternates periods of 2 and 3 source ticks, which makes the ratio exact over every pair of predivide periods.

Top module: `frac_clk_div`

## Requirements
- R1: After reset the read-back word is 0, `out_tick` and `cfg_err` are low, and no pulse appears while the enable bit is clear.
- R2: The configuration word has these fields: divisor in bits 6:0, predivide code in bits 9:8, PLL pick in bit 13, PLL-versus-crystal pick in bit 14, and enable in bit 15. Bits 7 and 12:10 read back as 0. Every other bit reads back as written.
- R3: Bit 14 = 0 selects `xtal_tick`. With bit 14 = 1, bit 13 = 0 selects `pll1_tick` and bit 13 = 1 selects `pll2_tick`.
- R4: Predivide code 1 divides by 2 and code 3 divides by 3. With such a code and divisor D in 2..127, consecutive pulses are exactly ratio×D source ticks apart.
- R5: Predivide code 2 divides by 2.5. Each pulse interval is 2.5×D source ticks rounded up or down, and any two consecutive intervals add up to exactly 5×D source ticks.
- R6: After a write that clears the enable bit, `out_tick` stays low from the second clock edge after the write onward.
- R7: A legal configuration written while the block is running takes effect only after the current output period ends. The interval that contains the write keeps its old length.
- R8: A write with the enable bit set and either predivide code 0 or divisor below 2 produces no pulses. It sets `cfg_err` one cycle later, and `cfg_err` stays set until reset, even after a legal configuration runs again.
- R9: If the configuration is enabled but illegal when a running period ends, that period still ends with its pulse, and the block then goes idle.
- R10: `out_tick` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_tick | input | 1 | Crystal reference strobe, one cycle per source edge |
| pll1_tick | input | 1 | First PLL reference strobe |
| pll2_tick | input | 1 | Second PLL reference strobe |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Current configuration word (reserved bits zero) |
| out_tick | output | 1 | Single-cycle pulse at the end of each output period |
| cfg_err | output | 1 | Sticky flag for an enabled illegal setting |

## Verification
The assertions check on every cycle that output is quiet after the enable bit drops, that pulses are single-cycle, that the error flag is set by an illegal enabled write and never falls, and that the active settings hold still inside an output period. The exact pulse spacing for each source, predivide code and divisor can only be shown by the bench's sweep. The same is true of the 2-plus-3 pairing of the 2.5 ratio, of the old period surviving a mid-period rewrite, and of the final pulse before an illegal reload goes idle.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int CFG_W     = 16;
  localparam int DIV_W     = 7;
  localparam int PRE_W     = 2;

  // field positions (software-visible layout)
  localparam int DIV_LSB   = 0;
  localparam int PRE_LSB   = 8;
  localparam int PSEL_BIT  = 13;
  localparam int ESEL_BIT  = 14;
  localparam int EN_BIT    = 15;

  localparam int MIN_DIV   = 2;

  typedef struct packed {
    logic             en;
    logic             esel;
    logic             psel;
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
  } cfg_t;

  function automatic cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.en   = w[EN_BIT];
    c.esel = w[ESEL_BIT];
    c.psel = w[PSEL_BIT];
    c.pre  = w[PRE_LSB +: PRE_W];
    c.div  = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[EN_BIT]              = c.en;
    w[ESEL_BIT]            = c.esel;
    w[PSEL_BIT]            = c.psel;
    w[PRE_LSB +: PRE_W]    = c.pre;
    w[DIV_LSB +: DIV_W]    = c.div;
    return w;
  endfunction

  function automatic logic cfg_legal(input cfg_t c);
    return (c.pre != '0) && (c.div >= DIV_W'(MIN_DIV));
  endfunction

endpackage

// File: rtl/cdiv_cfg_reg.sv
module cdiv_cfg_reg
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg,
  output logic [CFG_W-1:0] rdata,
  output logic             err
);

  cfg_t cfg_q;
  cfg_t wr_cfg;
  logic err_q;

  assign wr_cfg = cfg_unpack(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr) begin
        cfg_q <= wr_cfg;
        if (wr_cfg.en && !cfg_legal(wr_cfg)) begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign cfg   = cfg_q;
  assign rdata = cfg_pack(cfg_q);
  assign err   = err_q;

endmodule

// File: rtl/cdiv_src_sel.sv
module cdiv_src_sel #(
  parameter int N_SRC = 3
) (
  input  logic [N_SRC-1:0] ticks,
  input  logic             esel,
  input  logic             psel,
  output logic             tick_out
);

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [IDX_W-1:0] idx;
  logic [N_SRC-1:0] hit;

  // index 0: crystal, 1: first PLL, 2: second PLL
  always_comb begin
    if (!esel)     idx = IDX_W'(0);
    else if (psel) idx = IDX_W'(2);
    else           idx = IDX_W'(1);
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_pick
    assign hit[g] = ticks[g] && (idx == IDX_W'(g));
  end

  assign tick_out = |hit;

endmodule

// File: rtl/cdiv_predivider.sv
module cdiv_predivider #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              pulse
);

  localparam logic [CODE_W-1:0] CODE_HALF  = CODE_W'(2);
  localparam logic [CODE_W-1:0] CODE_THREE = CODE_W'(3);

  logic [1:0] cnt_q;
  logic       phase_q;
  logic [1:0] last;

  // terminal count: 1 for a 2-tick period, 2 for a 3-tick period
  always_comb begin
    if (code == CODE_THREE || (code == CODE_HALF && phase_q)) last = 2'd2;
    else                                                       last = 2'd1;
  end

  assign pulse = !clr && tick && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q == last) begin
        cnt_q <= '0;
        if (code == CODE_HALF) phase_q <= !phase_q;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

endmodule

// File: rtl/cdiv_intdivider.sv
module cdiv_intdivider #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         wrap
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  assign last = limit - W'(1);
  assign wrap = !clr && step && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (step) begin
      if (cnt_q == last) cnt_q <= '0;
      else               cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_tick,
  input  logic             pll1_tick,
  input  logic             pll2_tick,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             out_tick,
  output logic             cfg_err
);

  localparam int N_SRC = 3;

  cfg_t cfg_q;
  cfg_t act_q;
  logic run_q;
  logic clr;
  logic src_tick;
  logic pre_pulse;
  logic period_end;
  logic out_q;

  cdiv_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg_q),
    .rdata (cfg_rdata),
    .err   (cfg_err)
  );

  cdiv_src_sel #(.N_SRC(N_SRC)) u_src (
    .ticks    ({pll2_tick, pll1_tick, xtal_tick}),
    .esel     (act_q.esel),
    .psel     (act_q.psel),
    .tick_out (src_tick)
  );

  assign clr = !run_q;

  cdiv_predivider #(.CODE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .tick  (src_tick),
    .code  (act_q.pre),
    .pulse (pre_pulse)
  );

  cdiv_intdivider #(.W(DIV_W)) u_int (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .step  (pre_pulse),
    .limit (act_q.div),
    .wrap  (period_end)
  );

  // run control: start from idle, swap settings only at a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      act_q <= '0;
      out_q <= 1'b0;
    end else begin
      out_q <= period_end && cfg_q.en;
      if (!cfg_q.en) begin
        run_q <= 1'b0;
      end else if (!run_q) begin
        if (cfg_legal(cfg_q)) begin
          run_q <= 1'b1;
          act_q <= cfg_q;
        end
      end else if (period_end) begin
        if (cfg_legal(cfg_q)) act_q <= cfg_q;
        else                  run_q <= 1'b0;
      end
    end
  end

  assign out_tick = out_q;

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk
  import cdiv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             out_tick,
  input logic             cfg_err,
  input logic             run_q,
  input logic             period_end,
  input cfg_t             act_q
);

  // R6: enable clear silences the output from the next edge
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[EN_BIT] |=> !out_tick);

  // R10: pulses last one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |=> !out_tick);

  // R8: enabled illegal write raises the flag
  a_r8_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[EN_BIT] &&
     (cfg_wdata[PRE_LSB +: PRE_W] == '0 || cfg_wdata[DIV_LSB +: DIV_W] < DIV_W'(MIN_DIV)))
    |=> cfg_err);

  // R8: flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R7: active settings hold inside a running period
  a_r7_hold_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !period_end) |=> $stable(act_q));

endmodule

bind frac_clk_div frac_clk_div_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .out_tick   (out_tick),
  .cfg_err    (cfg_err),
  .run_q      (run_q),
  .period_end (period_end),
  .act_q      (act_q)
);

// File: tb/frac_clk_div_tb.sv
`timescale 1ns/1ps
module frac_clk_div_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_tick = 1'b0;
  logic        pll1_tick = 1'b0;
  logic        pll2_tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        out_tick;
  logic        cfg_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tgen = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  frac_clk_div u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtal_tick (xtal_tick),
    .pll1_tick (pll1_tick),
    .pll2_tick (pll2_tick),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .out_tick  (out_tick),
    .cfg_err   (cfg_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // crystal ticks every cycle, PLL1 every 2nd, PLL2 every 3rd
  always @(negedge clk) begin
    tgen = tgen + 1;
    xtal_tick = 1'b1;
    pll1_tick = (tgen % 2) == 0;
    pll2_tick = (tgen % 3) == 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input bit en, input bit esel, input bit psel,
                                     input int pre, input int div);
    logic [15:0] w;
    w = '0;
    w[15] = en; w[14] = esel; w[13] = psel;
    w[9:8] = pre[1:0];
    w[6:0] = div[6:0];
    return w;
  endfunction

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic wait_tick(input int limit, output int t, output bit ok);
    ok = 0; t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (out_tick) begin t = cyc; ok = 1; return; end
    end
  endtask

  task automatic count_ticks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_tick) cnt++;
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, n, d, per, T;
    bit ok0, ok1, ok2;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(cfg_rdata == 16'h0, "R1 rdata", cfg_rdata, 0);
    chk(out_tick == 1'b0, "R1 out_tick", out_tick, 0);
    chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);
    count_ticks(60, n);
    chk(n == 0, "R1 idle pulses", n, 0);

    // R2: layout and reserved bits
    wr(16'hFFFF);
    chk(cfg_rdata == 16'hE37F, "R2 readback", cfg_rdata, 16'hE37F);
    wr(16'h0000);
    wr(cw(0, 1, 0, 2, 77));
    chk(cfg_rdata == 16'h424D, "R2 fields", cfg_rdata, 16'h424D);
    wr(16'h0000);

    // R3/R4/R5 sweep
    for (int s = 0; s < 3; s++) begin
      T = s + 1;
      for (int pre = 1; pre <= 3; pre++) begin
        for (int k = 0; k < 22; k++) begin
          d = (k < 19) ? k + 2 : (k == 19) ? 63 : (k == 20) ? 64 : 127;
          wr(16'h0000);
          wr(cw(1, s != 0, s == 2, pre, d));
          wait_tick(4000, t0, ok0);
          wait_tick(4000, t1, ok1);
          wait_tick(4000, t2, ok2);
          if (pre != 2) begin
            per = T * ((pre == 1) ? 2 : 3) * d;
            tag = $sformatf("R3/R4 src%0d pre%0d div%0d", s, pre, d);
            chk(ok0 && ok1 && (t1 - t0) == per, tag, t1 - t0, per);
            chk(ok2 && (t2 - t1) == per, tag, t2 - t1, per);
          end else begin
            tag = $sformatf("R3/R5 src%0d div%0d", s, d);
            chk(ok0 && ok2 && (t2 - t0) == 5 * T * d, tag, t2 - t0, 5 * T * d);
            chk(ok1 && (2 * (t1 - t0) == 5 * T * d - T || 2 * (t1 - t0) == 5 * T * d ||
                        2 * (t1 - t0) == 5 * T * d + T), tag, 2 * (t1 - t0), 5 * T * d);
          end
        end
      end
    end

    // R6: disable stops output
    wr(cw(1, 0, 0, 1, 2));
    wait_tick(100, t0, ok0);
    wr(cw(0, 0, 0, 1, 2));
    @(negedge clk);
    count_ticks(100, n);
    chk(n == 0, "R6 pulses after disable", n, 0);

    // R7: mid-period rewrite keeps current period
    wr(cw(1, 0, 0, 1, 10));
    wait_tick(200, t0, ok0);
    wait_tick(200, t0, ok0);
    repeat (3) @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = cw(1, 0, 0, 3, 4);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
    wait_tick(200, t1, ok1);
    wait_tick(200, t2, ok2);
    chk(ok1 && (t1 - t0) == 20, "R7 old period", t1 - t0, 20);
    chk(ok2 && (t2 - t1) == 12, "R7 new period", t2 - t1, 12);

    chk(cfg_err == 1'b0, "R8 no error before illegal write", cfg_err, 0);

    // R8: illegal predivide code from idle
    wr(16'h0000);
    wr(cw(1, 0, 0, 0, 5));
    chk(cfg_err == 1'b1, "R8 err after pre0", cfg_err, 1);
    count_ticks(200, n);
    chk(n == 0, "R8 pulses with pre0", n, 0);

    // R9: illegal setting at reload finishes period then idles
    wr(cw(1, 0, 0, 1, 10));
    wait_tick(200, t0, ok0);
    repeat (3) @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = cw(1, 0, 0, 1, 1);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
    wait_tick(200, t1, ok1);
    chk(ok1 && (t1 - t0) == 20, "R9 last period", t1 - t0, 20);
    count_ticks(200, n);
    chk(n == 0, "R9 idle after illegal reload", n, 0);

    // R8: sticky across a legal run
    wr(cw(1, 0, 0, 3, 2));
    wait_tick(100, t0, ok0);
    wait_tick(100, t1, ok1);
    chk(ok1 && (t1 - t0) == 6, "R8 legal run after error", t1 - t0, 6);
    chk(cfg_err == 1'b1, "R8 err sticky", cfg_err, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule